// File: doc/BRIEF.md
# Hierarchical Interrupt Status Hub

This block gathers interrupt causes for a bus-interface controller into a single top-level status byte and one interrupt request line. Two of the status bits are summaries. One covers eleven bus-protocol causes and the other covers six DMA causes. Each cause is latched in its own bit of a detail register. The third status bit is a flag that an embedded sequencer raises to signal an interrupt without stopping its own program.

Cause events arrive as single-cycle pulses on the `proto_evt`, `dma_evt` and `fly_evt` inputs. Software reads through a small register port (`reg_sel`, `rd_en`, `wr_en`, `wr_data`), and `rd_data` combinationally shows the selected register. A read strobe on a detail register returns the latched causes and clears them at the same clock edge. A summary bit therefore drops as soon as every detail bit under it has been read out. The sequencer flag works differently. Reads do not touch it, and it goes away only when software writes a one to its bit.

The flag is held by a two-state machine. The states are `FLY_CLEAR` and `FLY_SET`. The transition `raise` (`fly_evt` high) moves either state to `FLY_SET`. The transition `ack` (a write of one to bit 2 with no `fly_evt`) moves `FLY_SET` to `FLY_CLEAR`. In every other cycle the machine holds its state.

Top module: `irq_status_hub`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: The top status register (address 0) holds the sequencer flag in bit 2, the protocol summary in bit 1 and the DMA summary in bit 0; bits 7..3 always read 0.
- R3: A `fly_evt` pulse sets bit 2 of the top register. The bit stays set across any number of reads of address 0.
- R4: A write to address 0 with `wr_data[2]`=1 clears the flag. A write with `wr_data[2]`=0 leaves the flag unchanged, whatever the other data bits hold.
- R5: When `fly_evt` and a flag-clearing write fall in the same cycle, the flag ends up set.
- R6: A pulse on `proto_evt[i]` latches a protocol cause. For i in 0..7 it appears at bit i of address 1, and for i in 8..10 it appears at bit i-8 of address 2. The bits of these registers above the cause count read 0.
- R7: A pulse on `dma_evt[i]`, for i in 0..5, latches bit i of address 3. Bits 7..6 read 0.
- R8: A detail register read with `rd_en` returns its latched value and clears it at that clock edge. A cause pulse arriving in the same cycle as the read stays latched after the edge.
- R9: Each summary bit is the OR of its detail bits. It clears without any write once those bits have all been read out.
- R10: `irq` is high exactly when any of the three top-level bits is set.
- R11: A read of one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proto_evt | input | 11 | Protocol-side cause pulses, one bit per cause |
| dma_evt | input | 6 | DMA-side cause pulses, one bit per cause |
| fly_evt | input | 1 | Sequencer non-halting interrupt pulse |
| reg_sel | input | 2 | Register select: 0 top, 1 protocol low, 2 protocol high, 3 DMA |
| rd_en | input | 1 | Read strobe; clears the selected detail register at the edge |
| wr_en | input | 1 | Write strobe; only address 0 bit 2 has an effect |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Contents of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a cycle in which a cause pulse lands on the same edge as the read-clear of its own register. The same difficulty applies to a flag set landing on the same edge as the write that clears the flag. The bench drives the event vector and the read or write strobe together in one cycle. It samples the read data before that edge and samples the register again after it. A sweep pulses every protocol and DMA cause on its own, and then walks all eight combinations of the three top-level sources.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int PROTO_CAUSES = 11;
    localparam int DMA_CAUSES   = 6;
    localparam int REG_W        = 8;
    localparam int ADDR_W       = 2;

    localparam logic [ADDR_W-1:0] A_TOP = 2'd0;
    localparam logic [ADDR_W-1:0] A_PLO = 2'd1;
    localparam logic [ADDR_W-1:0] A_PHI = 2'd2;
    localparam logic [ADDR_W-1:0] A_DMA = 2'd3;

    localparam int FLY_BIT   = 2;
    localparam int PROTO_BIT = 1;
    localparam int DMA_BIT   = 0;

    typedef enum logic {
        FLY_CLEAR = 1'b0,
        FLY_SET   = 1'b1
    } fly_state_t;
endpackage

// File: rtl/cause_latch.sv
module cause_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] kept;

    always_comb begin
        kept = rd_clr ? '0 : q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= kept | evt;
    end

    // R8
    evt_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((q & $past(evt)) == $past(evt)));
    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((q & ~$past(evt)) == '0));
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/fly_flag_fsm.sv
module fly_flag_fsm
    import irq_hub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    fly_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FLY_CLEAR: if (set_req) state_nx = FLY_SET;
            FLY_SET:   if (clr_req && !set_req) state_nx = FLY_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FLY_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        flag = (state == FLY_SET);
    end

    // R3
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    // R4
    ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !flag);
endmodule

// File: rtl/irq_status_hub.sv
module irq_status_hub
    import irq_hub_pkg::*;
#(
    parameter int N_PROTO = PROTO_CAUSES,
    parameter int N_DMA   = DMA_CAUSES,
    parameter int RW      = REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PROTO-1:0] proto_evt,
    input  logic [N_DMA-1:0]   dma_evt,
    input  logic               fly_evt,
    input  logic [ADDR_W-1:0]  reg_sel,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [RW-1:0]      wr_data,
    output logic [RW-1:0]      rd_data,
    output logic               irq
);
    localparam int PHI_W = N_PROTO - RW;
    localparam int PHI_PAD = RW - PHI_W;
    localparam int DMA_PAD = RW - N_DMA;
    localparam logic [RW-1:0] FLY_MASK = RW'(1) << FLY_BIT;

    logic [RW-1:0]    plo_q;
    logic [PHI_W-1:0] phi_q;
    logic [N_DMA-1:0] dma_q;
    logic             fly_q;
    logic             clr_req;
    logic             proto_sum, dma_sum;
    logic [RW-1:0]    top_q;

    always_comb begin
        clr_req = wr_en && (reg_sel == A_TOP) && ((wr_data & FLY_MASK) != '0);
    end

    cause_latch #(.W(RW)) u_plo (
        .clk(clk), .rst_n(rst_n), .evt(proto_evt[RW-1:0]),
        .rd_clr(rd_en && reg_sel == A_PLO), .q(plo_q));

    cause_latch #(.W(PHI_W)) u_phi (
        .clk(clk), .rst_n(rst_n), .evt(proto_evt[N_PROTO-1:RW]),
        .rd_clr(rd_en && reg_sel == A_PHI), .q(phi_q));

    cause_latch #(.W(N_DMA)) u_dma (
        .clk(clk), .rst_n(rst_n), .evt(dma_evt),
        .rd_clr(rd_en && reg_sel == A_DMA), .q(dma_q));

    fly_flag_fsm u_fly (
        .clk(clk), .rst_n(rst_n), .set_req(fly_evt),
        .clr_req(clr_req), .flag(fly_q));

    always_comb begin
        proto_sum = (plo_q != '0) || (phi_q != '0);
        dma_sum   = (dma_q != '0);
        top_q            = '0;
        top_q[FLY_BIT]   = fly_q;
        top_q[PROTO_BIT] = proto_sum;
        top_q[DMA_BIT]   = dma_sum;
        irq = |top_q;
    end

    always_comb begin
        unique case (reg_sel)
            A_TOP: rd_data = top_q;
            A_PLO: rd_data = plo_q;
            A_PHI: rd_data = {{PHI_PAD{1'b0}}, phi_q};
            A_DMA: rd_data = {{DMA_PAD{1'b0}}, dma_q};
        endcase
    end

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (fly_q || (plo_q != '0) || (phi_q != '0) || (dma_q != '0)));
    // R3
    top_read_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fly_q && rd_en && !wr_en) |=> fly_q);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fly_evt && clr_req) |=> fly_q);
endmodule

// File: tb/sim_irq_status_hub.sv
module sim_irq_status_hub;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [10:0] proto_evt = '0;
    logic [5:0]  dma_evt = '0;
    logic        fly_evt = 0;
    logic [1:0]  reg_sel = '0;
    logic        rd_en = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_status_hub u0 (
        .clk(clk), .rst_n(rst_n), .proto_evt(proto_evt), .dma_evt(dma_evt),
        .fly_evt(fly_evt), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    // non-clearing look at a register
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        reg_sel = a;
        #1 d = rd_data;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_sel = a;
        rd_en = 1;
        #1 d = rd_data;
        tick();
        rd_en = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        reg_sel = 2'd0;
        wr_data = v;
        wr_en = 1;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        tick(); tick();
        rst_n = 1;
        tick();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], d);
            chk("R1 reg", d, 8'h00);
        end
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R6 R9 R11 sweep of protocol causes
        for (int i = 0; i < 11; i++) begin
            proto_evt = 11'(1) << i; tick(); proto_evt = '0;
            peek(2'd0, d); chk("R2 top proto", d, 8'h02);
            chk("R10 irq proto", {7'b0, irq}, 8'h01);
            rd(2'd1, d); chk("R6 lo", d, (i < 8) ? 8'(1 << i) : 8'h00);
            peek(2'd2, d); chk("R11 hi kept", d, (i >= 8) ? 8'(1 << (i - 8)) : 8'h00);
            rd(2'd2, d); chk("R6 hi", d, (i >= 8) ? 8'(1 << (i - 8)) : 8'h00);
            peek(2'd0, d); chk("R9 proto drop", d, 8'h00);
            chk("R10 irq low", {7'b0, irq}, 8'h00);
        end

        // R7 R9 sweep of DMA causes
        for (int i = 0; i < 6; i++) begin
            dma_evt = 6'(1) << i; tick(); dma_evt = '0;
            peek(2'd0, d); chk("R2 top dma", d, 8'h01);
            rd(2'd3, d); chk("R7 dma", d, 8'(1 << i));
            peek(2'd0, d); chk("R9 dma drop", d, 8'h00);
        end

        // R3 R4 flag behaviour
        fly_evt = 1; tick(); fly_evt = 0;
        rd(2'd0, d); chk("R3 top", d, 8'h04);
        rd(2'd0, d); chk("R3 reread", d, 8'h04);
        chk("R10 irq fly", {7'b0, irq}, 8'h01);
        wr(8'h00); peek(2'd0, d); chk("R4 zero write", d, 8'h04);
        wr(8'hFB); peek(2'd0, d); chk("R4 other bits", d, 8'h04);
        wr(8'h04); peek(2'd0, d); chk("R4 clear", d, 8'h00);
        chk("R10 irq fly off", {7'b0, irq}, 8'h00);

        // R5 set beats clear
        fly_evt = 1; wr(8'h04); fly_evt = 0;
        peek(2'd0, d); chk("R5 set wins", d, 8'h04);
        wr(8'h04);

        // R8 pulse during read stays latched
        proto_evt = 11'h008; tick(); proto_evt = '0;
        proto_evt = 11'h028; rd(2'd1, d); proto_evt = '0;
        chk("R8 read value", d, 8'h08);
        peek(2'd1, d); chk("R8 kept", d, 8'h28);
        dma_evt = 6'h20; tick(); dma_evt = 6'h01; rd(2'd3, d); dma_evt = '0;
        chk("R8 dma read", d, 8'h20);
        rd(2'd3, d); chk("R8 dma kept", d, 8'h01);
        rd(2'd1, d); chk("R8 clear", d, 8'h28);

        // R2 R10 all combinations of the three sources
        for (int c = 0; c < 8; c++) begin
            fly_evt = c[2]; proto_evt = c[1] ? 11'h400 : '0; dma_evt = c[0] ? 6'h04 : '0;
            tick();
            fly_evt = 0; proto_evt = '0; dma_evt = '0;
            peek(2'd0, d); chk("R2 combo", d, 8'(c));
            chk("R10 combo irq", {7'b0, irq}, (c != 0) ? 8'h01 : 8'h00);
            rd(2'd2, d); rd(2'd3, d); wr(8'h04);
            peek(2'd0, d); chk("R9 combo cleared", d, 8'h00);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule